// File: doc/BRIEF.md
# Fused-Operation Execution Unit for an 8-bit Accumulator Core

This unit carries out the little-known combined operations of an 8-bit accumulator processor. Some of them fuse a read-modify-write step on a memory byte (a shift, a rotate, an increment or a decrement) with a following accumulator step (OR, AND, XOR, add, compare or subtract). Others mix the registers in unusual ways: AND followed by a rotate, stores masked with the incremented address high byte, and loads through the stack pointer. The surrounding core fetches the operand, decodes the opcode into a 4-bit select, and presents the accumulator, X, Y, the stack pointer low byte, the operand, the effective-address high byte and the N, V, Z, C and D flags. One clock later the unit returns the byte to write back, a write strobe, the new A, X and stack-pointer low byte, and the new flags.

Any flag that an operation does not define passes through from its input unchanged. The decimal-mode paths of the rotate-add and increment-subtract operations follow the older processor variant's BCD rules. That hardware can be left out with a parameter.

Top module: `uop_exec`

## Requirements
- R1: A synchronous active-high reset drives every output to zero: the strobe, the data, A, X, SP and all four flags.
- R2: Each result is registered and appears one clock after its inputs. Select 15 is a no-op: A, X, SP and the flags equal their inputs, and no write takes place.
- R3: Select 0 writes M<<1 and ORs it into A. Select 1 writes {M[6:0],C} and ANDs it into A. Select 2 writes M>>1 and XORs it into A. In each case C takes the bit shifted out, N and Z come from the new A, and V is unchanged.
- R4: Select 3 with D=0 writes W={C,M[7:1]}, then sets A=A+W+M[0] in binary. C is the carry out, V is the signed overflow, and N and Z come from A.
- R5: With D=1, selects 3 and 5 use BCD rules. Add: N and V come from the sum before the high-nibble adjust, and Z comes from the binary sum. Subtract: N, Z, V and C come from the binary difference, and A is the nibble-adjusted value.
- R6: Select 4 writes W=M-1 and leaves A unchanged. C=(A>=W), and N and Z come from A-W.
- R7: Select 5 with D=0 writes W=M+1 and sets A=A-W-(1-C). C is set when no borrow occurs, V is the signed overflow, and N and Z come from A.
- R8: Select 6 sets A=(A&M)>>1 with C equal to bit 0 of A&M. N is cleared and Z comes from A. Nothing is written.
- R9: Select 7 sets A=A&M, takes N and Z from A, and sets C equal to N. Nothing is written.
- R10: Select 8 with D=0 sets A={C,(A&M)[7:1]}. N and Z come from A, C=A[6] and V=A[6]^A[5].
- R11: Select 8 with D=1: R={C,T[7:1]} where T=A&M. N is the old C, Z comes from R, and V=(R^T)[6]. The low nibble gets +6 when its value plus R[0] exceeds 5. The high nibble gets +6 with C=1 when its value plus R[4] exceeds 5; otherwise C=0.
- R12: Selects 9, 10, 11 and 12 write (A&X), Y, X and (A&X) respectively, each ANDed with (addr_hi+1) mod 256. Select 12 also sets SP=A&X. These selects leave the flags unchanged.
- R13: Select 13 sets A, X and SP to M&SP, with N and Z from that value. Select 14 sets X=(A&X)-M, with C=((A&X)>=M) and N and Z from X.
- R14: The write strobe is 1 only for selects 0 to 5 and 9 to 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Operation select |
| a_in | input | 8 | Accumulator |
| x_in | input | 8 | X index register |
| y_in | input | 8 | Y index register |
| sp_in | input | 8 | Stack pointer low byte |
| mem_in | input | 8 | Memory operand |
| addr_hi | input | 8 | High byte of the effective address |
| n_in | input | 1 | Negative flag in |
| v_in | input | 1 | Overflow flag in |
| z_in | input | 1 | Zero flag in |
| c_in | input | 1 | Carry flag in |
| dec_in | input | 1 | Decimal mode flag |
| mem_wr | output | 1 | Write-back strobe |
| mem_wdata | output | 8 | Byte to write back |
| a_out | output | 8 | New accumulator |
| x_out | output | 8 | New X |
| sp_out | output | 8 | New stack pointer low byte |
| n_out | output | 1 | New negative flag |
| v_out | output | 1 | New overflow flag |
| z_out | output | 1 | New zero flag |
| c_out | output | 1 | New carry flag |

## Verification
The bench builds the unit with its default DEC_EN=1, so the BCD hardware is in place. Both settings of the decimal flag can then be driven through the rotate-add, increment-subtract and AND-rotate selects. With that setting the invalid-BCD operands, the low-nibble and high-nibble adjust thresholds, and the N/V flags taken from the pre-adjust sum can all be compared with an independent integer model. Every select is swept with pseudo-random operands that include carry-in, address-high wrap (0xFF+1) and zero results.

// File: rtl/uop_pkg.sv
package uop_pkg;
  localparam int BW   = 8;
  localparam int NW   = BW / 2;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_SHL_OR  = 4'd0,
    OP_ROL_AND = 4'd1,
    OP_SHR_XOR = 4'd2,
    OP_ROR_ADD = 4'd3,
    OP_DEC_CMP = 4'd4,
    OP_INC_SBC = 4'd5,
    OP_AND_SHR = 4'd6,
    OP_AND_CPY = 4'd7,
    OP_AND_ROR = 4'd8,
    OP_ST_AX   = 4'd9,
    OP_ST_Y    = 4'd10,
    OP_ST_X    = 4'd11,
    OP_ST_AXSP = 4'd12,
    OP_LD_MSP  = 4'd13,
    OP_SUB_AX  = 4'd14,
    OP_NOP     = 4'd15
  } uop_e;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } flags_t;
endpackage

// File: rtl/uop_bcd_arith.sv
module uop_bcd_arith
  import uop_pkg::*;
#(
  parameter bit DEC_EN = 1'b1
) (
  input  logic [BW-1:0] a,
  input  logic [BW-1:0] b,
  input  logic          cin,
  input  logic          dec,
  input  logic          sub,
  output logic [BW-1:0] res,
  output flags_t        fl
);
  localparam int XW = BW + 4;

  logic [BW:0]   bsum;
  logic [BW-1:0] bres;
  flags_t        bfl;

  always_comb begin
    if (sub) bsum = {1'b0, a} - {1'b0, b} - {{BW{1'b0}}, ~cin};
    else     bsum = {1'b0, a} + {1'b0, b} + {{BW{1'b0}}, cin};
    bres  = bsum[BW-1:0];
    bfl.n = bres[BW-1];
    bfl.z = (bres == '0);
    bfl.c = sub ? ~bsum[BW] : bsum[BW];
    bfl.v = sub ? ((a[BW-1] ^ b[BW-1]) & (a[BW-1] ^ bres[BW-1]))
                : (~(a[BW-1] ^ b[BW-1]) & (a[BW-1] ^ bres[BW-1]));
  end

  generate
    if (DEC_EN) begin : g_dec
      logic [NW+1:0] lo;
      logic [BW+1:0] sum;
      logic [XW-1:0] dlo, dv, hdiff;
      logic [BW-1:0] dres;
      flags_t        dfl;

      always_comb begin
        lo = '0; sum = '0; dlo = '0; dv = '0; hdiff = '0;
        dres = '0; dfl = '0;
        if (!sub) begin
          lo = {2'b0, a[NW-1:0]} + {2'b0, b[NW-1:0]} + {{(NW+1){1'b0}}, cin};
          if (lo > 6'd9) lo = lo + 6'd6;
          sum = {6'b0, lo[NW-1:0]} + {2'b0, a[BW-1:NW], 4'b0}
              + {2'b0, b[BW-1:NW], 4'b0} + ((lo > 6'd15) ? 10'h10 : 10'h0);
          dfl.n = sum[BW-1];
          dfl.v = (a[BW-1] ^ sum[BW-1]) & ~(a[BW-1] ^ b[BW-1]);
          dfl.z = (bres == '0);
          if (sum[BW:NW] > 5'd9) sum = sum + 10'h60;
          dfl.c = sum[BW+1] | sum[BW];
          dres  = sum[BW-1:0];
        end else begin
          dlo   = {8'b0, a[NW-1:0]} - {8'b0, b[NW-1:0]} - {11'b0, ~cin};
          hdiff = {4'b0, a[BW-1:NW], 4'b0} - {4'b0, b[BW-1:NW], 4'b0};
          if (dlo[NW]) dv = ((dlo - 12'd6) & 12'h00F) | (hdiff - 12'h010);
          else         dv = (dlo & 12'h00F) | hdiff;
          if (dv[BW]) dv = dv - 12'h060;
          dres = dv[BW-1:0];
          dfl  = bfl;
        end
      end

      assign res = dec ? dres : bres;
      assign fl  = dec ? dfl  : bfl;
    end else begin : g_bin
      assign res = bres;
      assign fl  = bfl;
    end
  endgenerate
endmodule

// File: rtl/uop_and_ror.sv
module uop_and_ror
  import uop_pkg::*;
#(
  parameter bit DEC_EN = 1'b1
) (
  input  logic [BW-1:0] a,
  input  logic [BW-1:0] m,
  input  logic          cin,
  input  logic          dec,
  output logic [BW-1:0] res,
  output flags_t        fl
);
  logic [BW-1:0] t, r;
  flags_t        bfl;

  assign t = a & m;
  assign r = {cin, t[BW-1:1]};

  always_comb begin
    bfl.n = r[BW-1];
    bfl.z = (r == '0);
    bfl.c = r[6];
    bfl.v = r[6] ^ r[5];
  end

  generate
    if (DEC_EN) begin : g_dec
      logic [BW-1:0] fx;
      flags_t        dfl;
      always_comb begin
        fx    = r;
        dfl.n = cin;
        dfl.z = (r == '0);
        dfl.v = r[6] ^ t[6];
        if (({1'b0, fx[NW-1:0]} + {4'b0, fx[0]}) > 5'd5)
          fx[NW-1:0] = fx[NW-1:0] + 4'd6;
        if (({1'b0, fx[BW-1:NW]} + {4'b0, fx[NW]}) > 5'd5) begin
          fx[BW-1:NW] = fx[BW-1:NW] + 4'd6;
          dfl.c = 1'b1;
        end else begin
          dfl.c = 1'b0;
        end
      end
      assign res = dec ? fx  : r;
      assign fl  = dec ? dfl : bfl;
    end else begin : g_bin
      assign res = r;
      assign fl  = bfl;
    end
  endgenerate
endmodule

// File: rtl/uop_exec.sv
module uop_exec
  import uop_pkg::*;
#(
  parameter bit DEC_EN = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] op,
  input  logic [BW-1:0]   a_in,
  input  logic [BW-1:0]   x_in,
  input  logic [BW-1:0]   y_in,
  input  logic [BW-1:0]   sp_in,
  input  logic [BW-1:0]   mem_in,
  input  logic [BW-1:0]   addr_hi,
  input  logic            n_in,
  input  logic            v_in,
  input  logic            z_in,
  input  logic            c_in,
  input  logic            dec_in,
  output logic            mem_wr,
  output logic [BW-1:0]   mem_wdata,
  output logic [BW-1:0]   a_out,
  output logic [BW-1:0]   x_out,
  output logic [BW-1:0]   sp_out,
  output logic            n_out,
  output logic            v_out,
  output logic            z_out,
  output logic            c_out
);
  uop_e          sel;
  logic [BW-1:0] mask, ax, am, ar_b, ar_res, rr_res, k_a, k_x, k_sp, k_wd, tmp;
  logic [BW:0]   diff;
  logic          ar_cin, k_wr;
  flags_t        ar_fl, rr_fl, k_fl;

  assign sel  = uop_e'(op);
  assign mask = addr_hi + 8'd1;
  assign ax   = a_in & x_in;
  assign am   = a_in & mem_in;
  assign ar_b   = (sel == OP_ROR_ADD) ? {c_in, mem_in[BW-1:1]} : mem_in + 8'd1;
  assign ar_cin = (sel == OP_ROR_ADD) ? mem_in[0] : c_in;

  uop_bcd_arith #(.DEC_EN(DEC_EN)) u_arith (
    .a(a_in), .b(ar_b), .cin(ar_cin), .dec(dec_in),
    .sub(sel == OP_INC_SBC), .res(ar_res), .fl(ar_fl)
  );

  uop_and_ror #(.DEC_EN(DEC_EN)) u_arr (
    .a(a_in), .m(mem_in), .cin(c_in), .dec(dec_in), .res(rr_res), .fl(rr_fl)
  );

  always_comb begin
    k_a  = a_in;  k_x = x_in;  k_sp = sp_in;
    k_wr = 1'b0;  k_wd = '0;   tmp = '0;  diff = '0;
    k_fl = '{n: n_in, v: v_in, z: z_in, c: c_in};
    unique case (sel)
      OP_SHL_OR, OP_ROL_AND, OP_SHR_XOR: begin
        k_wr = 1'b1;
        if (sel == OP_SHR_XOR) begin
          k_wd = {1'b0, mem_in[BW-1:1]};  k_fl.c = mem_in[0];  k_a = a_in ^ k_wd;
        end else begin
          k_wd = {mem_in[BW-2:0], (sel == OP_ROL_AND) & c_in};
          k_fl.c = mem_in[BW-1];
          k_a = (sel == OP_ROL_AND) ? (a_in & k_wd) : (a_in | k_wd);
        end
        k_fl.n = k_a[BW-1];  k_fl.z = (k_a == '0);
      end
      OP_ROR_ADD, OP_INC_SBC: begin
        k_wr = 1'b1;  k_wd = ar_b;  k_a = ar_res;  k_fl = ar_fl;
      end
      OP_DEC_CMP, OP_SUB_AX: begin
        tmp  = (sel == OP_DEC_CMP) ? mem_in - 8'd1 : mem_in;
        diff = {1'b0, (sel == OP_DEC_CMP) ? a_in : ax} - {1'b0, tmp};
        k_fl.c = ~diff[BW];  k_fl.n = diff[BW-1];  k_fl.z = (diff[BW-1:0] == '0);
        if (sel == OP_DEC_CMP) begin k_wr = 1'b1;  k_wd = tmp; end
        else k_x = diff[BW-1:0];
      end
      OP_AND_SHR: begin
        k_a = {1'b0, am[BW-1:1]};  k_fl.c = am[0];  k_fl.n = 1'b0;  k_fl.z = (k_a == '0);
      end
      OP_AND_CPY: begin
        k_a = am;  k_fl.n = am[BW-1];  k_fl.c = am[BW-1];  k_fl.z = (am == '0);
      end
      OP_AND_ROR: begin
        k_a = rr_res;  k_fl = rr_fl;
      end
      OP_ST_AX, OP_ST_Y, OP_ST_X, OP_ST_AXSP: begin
        k_wr = 1'b1;
        if (sel == OP_ST_Y)      k_wd = y_in & mask;
        else if (sel == OP_ST_X) k_wd = x_in & mask;
        else                     k_wd = ax & mask;
        if (sel == OP_ST_AXSP)   k_sp = ax;
      end
      OP_LD_MSP: begin
        tmp = mem_in & sp_in;
        k_a = tmp;  k_x = tmp;  k_sp = tmp;
        k_fl.n = tmp[BW-1];  k_fl.z = (tmp == '0);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_wr <= 1'b0;  mem_wdata <= '0;  a_out <= '0;  x_out <= '0;  sp_out <= '0;
      n_out  <= 1'b0;  v_out <= 1'b0;  z_out <= 1'b0;  c_out <= 1'b0;
    end else begin
      mem_wr <= k_wr;  mem_wdata <= k_wd;  a_out <= k_a;  x_out <= k_x;  sp_out <= k_sp;
      n_out  <= k_fl.n;  v_out <= k_fl.v;  z_out <= k_fl.z;  c_out <= k_fl.c;
    end
  end

  // R14
  wr_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && mem_wr) |-> ($past(op) <= 4'd5 || ($past(op) >= 4'd9 && $past(op) <= 4'd12)));
  // R8
  shr_n_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == 4'd6) |-> (!n_out && !mem_wr && (z_out == (a_out == '0))));
  // R9
  cpy_c_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == 4'd7) |-> (c_out == n_out));
  // R12
  mask_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) >= 4'd9 && $past(op) <= 4'd12)
      |-> ((mem_wdata & ~($past(addr_hi) + 8'd1)) == '0));
  // R13
  ldsp_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == 4'd13) |-> (a_out == x_out && x_out == sp_out));
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == 4'd15) |-> (a_out == $past(a_in) && sp_out == $past(sp_in) && !mem_wr));
endmodule

// File: tb/sim_uop_exec.sv
`timescale 1ns/1ps
module sim_uop_exec;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] op = '0;
  logic [7:0] a_in = '0, x_in = '0, y_in = '0, sp_in = '0, mem_in = '0, addr_hi = '0;
  logic n_in = 1'b0, v_in = 1'b0, z_in = 1'b0, c_in = 1'b0, dec_in = 1'b0;
  logic mem_wr, n_out, v_out, z_out, c_out;
  logic [7:0] mem_wdata, a_out, x_out, sp_out;

  always #2.5 clk = ~clk;

  uop_exec u0 (.*);

  typedef struct {
    logic [36:0] vec;
    string       tag;
  } item_t;

  item_t q[$];
  int total = 0, bad = 0;
  int seed = 32'h1A2B3C4D;
  bit done = 1'b0;

  function automatic logic [36:0] pack(int wr, int wd, int a, int x, int sp,
                                       int n, int v, int z, int c);
    logic [36:0] r;
    r = {wr[0], wd[7:0], a[7:0], x[7:0], sp[7:0], n[0], v[0], z[0], c[0]};
    return r;
  endfunction

  // Independent integer reference built from the requirement text
  function automatic logic [36:0] model(int o, int a, int x, int y, int sp, int m, int hi,
                                        int n, int v, int z, int c, int d);
    int wr = 0, wd = 0, ra = a, rx = x, rsp = sp, t, t2, lo, val, mk;
    mk = (hi + 1) & 255;
    case (o)
      0: begin wd = (m << 1) & 255; c = (m >> 7) & 1; ra = a | wd; wr = 1; end
      1: begin wd = ((m << 1) | c) & 255; c = (m >> 7) & 1; ra = a & wd; wr = 1; end
      2: begin wd = m >> 1; c = m & 1; ra = a ^ wd; wr = 1; end
      3, 5: begin
        wr = 1;
        if (o == 3) begin t = (m >> 1) | (c << 7); c = m & 1; end
        else t = (m + 1) & 255;
        wd = t;
        if (o == 3 && d) begin
          lo = (a & 15) + (t & 15) + c;
          if (lo > 9) lo += 6;
          val = (lo & 15) + (a & 240) + (t & 240) + ((lo > 15) ? 16 : 0);
          z = (((a + t + c) & 255) == 0);
          n = (val >> 7) & 1;
          v = (((a ^ val) & 128) != 0) && (((a ^ t) & 128) == 0);
          if ((val & 'h1F0) > 'h90) val += 'h60;
          c = ((val & 'hFF0) > 'hF0);
          ra = val & 255;
        end else if (o == 3) begin
          val = a + t + c;
          ra = val & 255;
          c = (val > 255);
          v = (((a ^ t) & 128) == 0) && (((a ^ ra) & 128) != 0);
          n = (ra >> 7) & 1; z = (ra == 0);
        end else begin
          t2 = a - t - (1 - c);
          if (d) begin
            lo = (a & 15) - (t & 15) - (1 - c);
            if (lo & 16) val = ((lo - 6) & 15) | ((a & 240) - (t & 240) - 16);
            else         val = (lo & 15) | ((a & 240) - (t & 240));
            if (val & 256) val -= 96;
            ra = val & 255;
          end else ra = t2 & 255;
          c = (t2 >= 0);
          n = ((t2 & 255) >> 7) & 1; z = ((t2 & 255) == 0);
          v = (((a ^ t2) & 128) != 0) && (((a ^ t) & 128) != 0);
        end
        if (o == 3 && d) begin end
        else if (o == 3) begin end
        wr = 1;
        return pack(wr, wd, ra, rx, rsp, n, v, z, c);
      end
      4: begin
        wd = (m - 1) & 255; wr = 1; c = (a >= wd);
        t = (a - wd) & 255; n = (t >> 7) & 1; z = (t == 0);
        return pack(wr, wd, ra, rx, rsp, n, v, z, c);
      end
      6: begin t = a & m; c = t & 1; ra = t >> 1; n = 0; z = (ra == 0);
        return pack(wr, wd, ra, rx, rsp, n, v, z, c); end
      7: begin ra = a & m; n = (ra >> 7) & 1; z = (ra == 0); c = n;
        return pack(wr, wd, ra, rx, rsp, n, v, z, c); end
      8: begin
        t = a & m; val = (t >> 1) | (c << 7);
        if (d) begin
          n = c; z = (val == 0); v = ((val ^ t) >> 6) & 1;
          if (((val & 15) + (val & 1)) > 5) val = (val & 240) | ((val + 6) & 15);
          if (((val & 240) + (val & 16)) > 'h50) begin val = (val & 15) | ((val + 'h60) & 240); c = 1; end
          else c = 0;
        end else begin
          n = (val >> 7) & 1; z = (val == 0); c = (val >> 6) & 1;
          v = ((val >> 6) ^ (val >> 5)) & 1;
        end
        ra = val & 255;
        return pack(wr, wd, ra, rx, rsp, n, v, z, c);
      end
      9:  begin wr = 1; wd = a & x & mk; end
      10: begin wr = 1; wd = y & mk; end
      11: begin wr = 1; wd = x & mk; end
      12: begin wr = 1; wd = a & x & mk; rsp = a & x; end
      13: begin t = m & sp; ra = t; rx = t; rsp = t; n = (t >> 7) & 1; z = (t == 0);
        return pack(wr, wd, ra, rx, rsp, n, v, z, c); end
      14: begin t = a & x; c = (t >= m); rx = (t - m) & 255; n = (rx >> 7) & 1; z = (rx == 0);
        return pack(wr, wd, ra, rx, rsp, n, v, z, c); end
      default: ;
    endcase
    if (o <= 2) begin n = (ra >> 7) & 1; z = ((ra & 255) == 0); end
    return pack(wr, wd, ra, rx, rsp, n, v, z, c);
  endfunction

  function automatic string tag_of(int o, int d);
    case (o)
      0, 1, 2:        return "R3 R14";
      3:              return d ? "R5 R14" : "R4 R14";
      4:              return "R6 R14";
      5:              return d ? "R5 R14" : "R7 R14";
      6:              return "R8 R14";
      7:              return "R9 R14";
      8:              return d ? "R11" : "R10";
      9, 10, 11, 12:  return "R12 R14";
      13, 14:         return "R13";
      default:        return "R2 R14";
    endcase
  endfunction

  task automatic apply(int o, int a, int x, int y, int sp, int m, int hi, int fl, int d);
    item_t it;
    @(negedge clk);
    op = o[3:0]; a_in = a[7:0]; x_in = x[7:0]; y_in = y[7:0]; sp_in = sp[7:0];
    mem_in = m[7:0]; addr_hi = hi[7:0];
    n_in = fl[3]; v_in = fl[2]; z_in = fl[1]; c_in = fl[0]; dec_in = d[0];
    it.vec = model(o, a & 255, x & 255, y & 255, sp & 255, m & 255, hi & 255,
                   (fl >> 3) & 1, (fl >> 2) & 1, (fl >> 1) & 1, fl & 1, d & 1);
    it.tag = tag_of(o, d & 1);
    q.push_back(it);
  endtask

  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 8) & 32'h7FFF;
  endfunction

  // Monitor: compares each registered result one clock after its inputs (R2)
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        logic [36:0] act;
        it  = q.pop_front();
        act = {mem_wr, mem_wdata, a_out, x_out, sp_out, n_out, v_out, z_out, c_out};
        total++;
        if (act !== it.vec) begin
          bad++;
          $display("FAIL %s actual=%h expected=%h (op=%0d)", it.tag, act, it.vec, op);
        end
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset clears every output even with busy inputs
    op = 4'd12; a_in = 8'hFF; x_in = 8'hFF; mem_in = 8'h55; c_in = 1'b1; n_in = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if ({mem_wr, mem_wdata, a_out, x_out, sp_out, n_out, v_out, z_out, c_out} !== '0) begin
      bad++;
      $display("FAIL R1 actual=%h expected=0",
               {mem_wr, mem_wdata, a_out, x_out, sp_out, n_out, v_out, z_out, c_out});
    end
    rst = 1'b0;

    // Directed corners
    apply(0, 8'h01, 0, 0, 0, 8'h80, 0, 4'b0000, 0);   // R3 carry out, A=1
    apply(2, 8'h00, 0, 0, 0, 8'h01, 0, 4'b0000, 0);   // R3 zero result
    apply(3, 8'h15, 0, 0, 0, 8'h10, 0, 4'b0000, 1);   // R5 BCD add
    apply(3, 8'h99, 0, 0, 0, 8'h03, 0, 4'b0000, 1);   // R5 BCD wrap
    apply(3, 8'h7F, 0, 0, 0, 8'h02, 0, 4'b0000, 0);   // R4 overflow
    apply(5, 8'h00, 0, 0, 0, 8'h00, 0, 4'b0001, 1);   // R5 BCD borrow
    apply(5, 8'h50, 0, 0, 0, 8'hAF, 0, 4'b0001, 0);   // R7 overflow
    apply(4, 8'h10, 0, 0, 0, 8'h11, 0, 4'b0000, 0);   // R6 equal -> Z,C
    apply(4, 8'h10, 0, 0, 0, 8'h00, 0, 4'b0000, 0);   // R6 M=0 wraps to FF
    apply(6, 8'hFF, 0, 0, 0, 8'h81, 0, 4'b1000, 0);   // R8 N cleared
    apply(7, 8'hF0, 0, 0, 0, 8'h80, 0, 4'b0000, 0);   // R9 C=N=1
    apply(8, 8'hFF, 0, 0, 0, 8'hFF, 0, 4'b0001, 0);   // R10
    apply(8, 8'hFF, 0, 0, 0, 8'hBB, 0, 4'b0001, 1);   // R11 both adjusts
    apply(8, 8'hFF, 0, 0, 0, 8'h22, 0, 4'b0000, 1);   // R11 no adjust
    apply(9, 8'hFF, 8'hFF, 0, 0, 0, 8'hFF, 4'b1111, 0); // R12 mask wraps to 0
    apply(12, 8'hF3, 8'h3F, 0, 8'h01, 0, 8'h12, 4'b0000, 0); // R12 SP load
    apply(13, 0, 0, 0, 8'hF0, 8'h9C, 0, 4'b0000, 0);  // R13
    apply(14, 8'h0F, 8'h07, 0, 0, 8'h08, 0, 4'b0000, 0); // R13 borrow
    apply(15, 8'h5A, 8'hA5, 0, 8'h33, 8'hFF, 0, 4'b1010, 1); // R2 no-op

    // Sweep every select over pseudo-random operands and both decimal settings
    for (int o = 0; o < 16; o++) begin
      for (int k = 0; k < 24; k++) begin
        apply(o, rnd(), rnd(), rnd(), rnd(), rnd(), (k == 3) ? 255 : rnd(),
              rnd() & 15, k & 1);
      end
    end

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule